// File: doc/BRIEF.md
# Multi-Bank DRAM Write Legality Monitor

This block sits beside a synchronous DRAM command bus and watches the commands a controller issues. For every bank it tracks whether a row is open and which row it is. It checks each write against that state: the target bank must be open, and the row given with the write must be the row that is open there. A change of row in the same bank needs a precharge and then a fresh activate before the next write. An activate sent to a bank that is already open is also reported.

A legal write that arrives while an earlier write burst is still moving is not an error. The newer write takes over, and the monitor reports a burst interruption pulse. Error and interruption outputs are registered pulses one clock after the offending command. The per-bank open flags and open rows are exported so that a bench or a scoreboard can follow the bank state.

Top module: `dram_wr_legality_mon`

## Requirements
- R1: While rst_ni is low, and after its release until a command is accepted, every bank reads idle, err_o and intr_o are 0 and err_code_o is 0.
- R2: cmd_i = 1 (activate) to an idle bank marks that bank open and records row_i as its open row. Both are visible on the outputs one clock after the command.
- R3: An activate to a bank that is already open gives err_o = 1 with err_code_o = 3, and it leaves that bank's open row unchanged.
- R4: cmd_i = 2 (precharge) makes the addressed bank idle and leaves other banks as they were. A precharge to an idle bank raises no error.
- R5: cmd_i = 3 (precharge all) makes every bank idle.
- R6: cmd_i = 4 (write) to an idle bank gives err_o = 1 with err_code_o = 1.
- R7: A write to an open bank whose row_i equals the open row is legal (err_o = 0). This includes writes on consecutive clocks.
- R8: A write to an open bank with a different row_i gives err_o = 1 with err_code_o = 2. After a precharge and an activate of the new row, the write is legal.
- R9: A write to a bank other than the previous write's bank is legal if that bank is open, and is subject to R6 otherwise.
- R10: A legal write issued fewer than BURST_LEN clocks after the previous legal write raises intr_o for one clock, with err_o = 0. At a spacing of BURST_LEN clocks or more, intr_o stays 0.
- R11: err_o is a one-clock pulse per illegal command, and err_code_o is 0 whenever err_o is 0. An illegal command changes no bank state. Codes 0, 5, 6 and 7 on cmd_i act as no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command: 0 nop, 1 activate, 2 precharge, 3 precharge all, 4 write |
| bank_i | input | BANK_W | Target bank |
| row_i | input | ROW_W | Row address for activate and write |
| err_o | output | 1 | One-clock pulse for an illegal command |
| err_code_o | output | 2 | 0 none, 1 write to idle bank, 2 row mismatch, 3 activate to open bank |
| intr_o | output | 1 | One-clock pulse when a legal write cuts short a running burst |
| bank_active_o | output | NUM_BANKS | Per-bank open flag |
| bank_row_o | output | NUM_BANKS*ROW_W | Per-bank open row, bank 0 in the low bits |

## Verification
The bench builds the monitor with four banks, a 6-bit row and BURST_LEN = 4. With a burst of 4, both sides of the interruption window fit in a few clocks: a write three clocks after the last one and a write four clocks after it. The narrow row keeps the open-row compare small while still allowing distinct rows per bank. Four banks are enough to exercise single-bank precharge against precharge-all and writes that hop between banks.

// File: rtl/dwm_pkg.sv
package dwm_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_PRE  = 3'd2,
    CMD_PREA = 3'd3,
    CMD_WR   = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_IDLE     = 2'd1,
    ERR_ROW      = 2'd2,
    ERR_ACT_OPEN = 2'd3
  } err_e;
endpackage

// File: rtl/dwm_bank_table.sv
module dwm_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       act_en_i,
  input  logic                       pre_en_i,
  input  logic                       prea_en_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [ROW_W-1:0]           row_i,
  output logic [NUM_BANKS-1:0]       active_o,
  output logic [NUM_BANKS*ROW_W-1:0] rows_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             hit;
    logic             valid_q;
    logic [ROW_W-1:0] row_q;

    assign hit = (int'(bank_i) == b);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        row_q   <= '0;
      end else if (prea_en_i || (pre_en_i && hit)) begin
        valid_q <= 1'b0;
      end else if (act_en_i && hit) begin
        valid_q <= 1'b1;
        row_q   <= row_i;
      end
    end

    assign active_o[b]                  = valid_q;
    assign rows_o[b*ROW_W +: ROW_W]     = row_q;
  end
endmodule

// File: rtl/dwm_cmd_check.sv
module dwm_cmd_check
  import dwm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [2:0]                 cmd_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [NUM_BANKS-1:0]       active_i,
  input  logic [NUM_BANKS*ROW_W-1:0] rows_i,
  output logic                       act_en_o,
  output logic                       pre_en_o,
  output logic                       prea_en_o,
  output logic                       wr_ok_o,
  output err_e                       err_o
);
  logic             bank_ok;
  logic             open;
  logic [ROW_W-1:0] open_row;
  cmd_e             cmd;

  assign cmd     = cmd_e'(cmd_i);
  assign bank_ok = (int'(bank_i) < NUM_BANKS);

  always_comb begin
    open     = 1'b0;
    open_row = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_ok && int'(bank_i) == b) begin
        open     = active_i[b];
        open_row = rows_i[b*ROW_W +: ROW_W];
      end
    end
  end

  always_comb begin
    act_en_o  = 1'b0;
    pre_en_o  = 1'b0;
    prea_en_o = 1'b0;
    wr_ok_o   = 1'b0;
    err_o     = ERR_NONE;
    unique case (cmd)
      CMD_ACT: begin
        if (open) err_o    = ERR_ACT_OPEN;
        else      act_en_o = bank_ok;
      end
      CMD_PRE:  pre_en_o  = 1'b1;
      CMD_PREA: prea_en_o = 1'b1;
      CMD_WR: begin
        if (!open)                 err_o   = ERR_IDLE;
        else if (row_i != open_row) err_o  = ERR_ROW;
        else                       wr_ok_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dwm_burst_tracker.sv
module dwm_burst_tracker #(
  parameter int BURST_LEN = 8,
  localparam int CNT_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ok_i,
  output logic intr_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] beats_q;
  logic             busy;

  assign busy = (beats_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beats_q <= '0;
      intr_o  <= 1'b0;
    end else begin
      intr_o <= wr_ok_i && busy;
      if (wr_ok_i)   beats_q <= RELOAD;
      else if (busy) beats_q <= beats_q - 1'b1;
    end
  end
endmodule

// File: rtl/dram_wr_legality_mon.sv
module dram_wr_legality_mon
  import dwm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BURST_LEN = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2:0]                 cmd_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [ROW_W-1:0]           row_i,
  output logic                       err_o,
  output logic [1:0]                 err_code_o,
  output logic                       intr_o,
  output logic [NUM_BANKS-1:0]       bank_active_o,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row_o
);
  logic act_en, pre_en, prea_en, wr_ok;
  err_e err_d;

  dwm_cmd_check #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_check (
    .cmd_i     (cmd_i),
    .bank_i    (bank_i),
    .row_i     (row_i),
    .active_i  (bank_active_o),
    .rows_i    (bank_row_o),
    .act_en_o  (act_en),
    .pre_en_o  (pre_en),
    .prea_en_o (prea_en),
    .wr_ok_o   (wr_ok),
    .err_o     (err_d)
  );

  dwm_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_en_i  (act_en),
    .pre_en_i  (pre_en),
    .prea_en_i (prea_en),
    .bank_i    (bank_i),
    .row_i     (row_i),
    .active_o  (bank_active_o),
    .rows_o    (bank_row_o)
  );

  dwm_burst_tracker #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_ok_i (wr_ok),
    .intr_o  (intr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
    end else begin
      err_o      <= (err_d != ERR_NONE);
      err_code_o <= err_d;
    end
  end
endmodule

// File: rtl/dwm_checker.sv
module dwm_checker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [2:0]                 cmd_i,
  input logic [BANK_W-1:0]          bank_i,
  input logic [ROW_W-1:0]           row_i,
  input logic                       err_o,
  input logic [1:0]                 err_code_o,
  input logic                       intr_o,
  input logic [NUM_BANKS-1:0]       bank_active_o,
  input logic [NUM_BANKS*ROW_W-1:0] bank_row_o
);
  logic             sel_open;
  logic [ROW_W-1:0] sel_row;

  always_comb begin
    sel_open = 1'b0;
    sel_row  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(bank_i) == b) begin
        sel_open = bank_active_o[b];
        sel_row  = bank_row_o[b*ROW_W +: ROW_W];
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> (bank_active_o == '0) && !err_o && !intr_o); // R1

  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && !sel_open) |=> !err_o && (bank_active_o != '0)); // R2

  AST_ACT_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && sel_open) |=> err_o && err_code_o == 2'd3 && $stable(bank_row_o)); // R3

  AST_PREA_ALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd3) |=> (bank_active_o == '0) && !err_o); // R5

  AST_WR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4 && !sel_open) |=> err_o && err_code_o == 2'd1); // R6

  AST_WR_SAME_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4 && sel_open && row_i == sel_row) |=> !err_o); // R7

  AST_WR_ROW_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4 && sel_open && row_i != sel_row) |=> err_o && err_code_o == 2'd2); // R8

  AST_INTR_NOT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> !err_o && $past(cmd_i) == 3'd4); // R10

  AST_CODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> err_code_o == 2'd0); // R11

  AST_ERR_NO_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(bank_active_o)); // R11
endmodule

bind dram_wr_legality_mon dwm_checker #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_i         (cmd_i),
  .bank_i        (bank_i),
  .row_i         (row_i),
  .err_o         (err_o),
  .err_code_o    (err_code_o),
  .intr_o        (intr_o),
  .bank_active_o (bank_active_o),
  .bank_row_o    (bank_row_o)
);

// File: tb/dram_wr_legality_mon_tb.sv
module dram_wr_legality_mon_tb;
  localparam int NB  = 4;
  localparam int RW  = 6;
  localparam int BL  = 4;
  localparam int BW  = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    cmd_i = 3'd0;
  logic [BW-1:0] bank_i = '0;
  logic [RW-1:0] row_i = '0;
  logic          err_o;
  logic [1:0]    err_code_o;
  logic          intr_o;
  logic [NB-1:0] bank_active_o;
  logic [NB*RW-1:0] bank_row_o;

  int checks = 0;
  int errors = 0;

  int m_open[NB];
  int m_row[NB];
  int m_rem = 0;

  always #4 clk_i = ~clk_i;

  dram_wr_legality_mon #(.NUM_BANKS(NB), .ROW_W(RW), .BURST_LEN(BL)) u_dut (
    .clk_i, .rst_ni, .cmd_i, .bank_i, .row_i,
    .err_o, .err_code_o, .intr_o, .bank_active_o, .bank_row_o
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag, input int e_err, input int e_code, input int e_intr);
    chk(err_o == e_err[0], tag, "err_o", int'(err_o), e_err);
    chk(int'(err_code_o) == e_code, tag, "err_code_o", int'(err_code_o), e_code);
    chk(intr_o == e_intr[0], tag, "intr_o", int'(intr_o), e_intr);
    for (int b = 0; b < NB; b++) begin
      chk(bank_active_o[b] == m_open[b][0], tag, $sformatf("active[%0d]", b),
          int'(bank_active_o[b]), m_open[b]);
      if (m_open[b] != 0)
        chk(int'(bank_row_o[b*RW +: RW]) == m_row[b], tag, $sformatf("row[%0d]", b),
            int'(bank_row_o[b*RW +: RW]), m_row[b]);
    end
  endtask

  // Drive at negedge, model the next state, compare after the following posedge.
  task automatic issue(input int cmd, input int bank, input int row, input string tag);
    int code = 0;
    int wr_ok = 0;
    int e_intr;
    @(negedge clk_i);
    cmd_i  = 3'(cmd);
    bank_i = BW'(bank);
    row_i  = RW'(row);
    case (cmd)
      1: if (m_open[bank] != 0) code = 3; else begin m_open[bank] = 1; m_row[bank] = row; end
      2: m_open[bank] = 0;
      3: for (int b = 0; b < NB; b++) m_open[b] = 0;
      4: if (m_open[bank] == 0) code = 1;
         else if (m_row[bank] != row) code = 2;
         else wr_ok = 1;
      default: ;
    endcase
    e_intr = (wr_ok != 0 && m_rem > 0) ? 1 : 0;
    if (wr_ok != 0) m_rem = BL - 1;
    else if (m_rem > 0) m_rem--;
    @(posedge clk_i);
    #1;
    compare(tag, (code != 0) ? 1 : 0, code, e_intr);
  endtask

  task automatic nops(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(0, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; end
    repeat (3) @(posedge clk_i);
    #1 compare("R1", 0, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1 compare("R1", 0, 0, 0);

    issue(1, 0, 5, "R2");
    issue(4, 0, 5, "R7");
    issue(4, 0, 5, "R10");          // next clock: legal and interrupts
    nops(4, "R11");
    issue(4, 0, 5, "R10");          // spacing 5: no interrupt
    nops(2, "R11");
    issue(4, 0, 5, "R10");          // spacing 3 = BL-1: interrupt
    nops(3, "R11");
    issue(4, 0, 5, "R10");          // spacing 4 = BL: no interrupt
    issue(4, 1, 0, "R6");
    issue(1, 0, 9, "R3");
    issue(4, 0, 9, "R8");
    issue(2, 0, 0, "R4");
    issue(1, 0, 9, "R8");
    issue(4, 0, 9, "R8");
    issue(1, 1, 2, "R9");
    issue(4, 1, 2, "R9");
    issue(4, 0, 9, "R9");
    issue(2, 2, 0, "R4");           // precharge of idle bank
    issue(1, 2, 7, "R2");
    issue(1, 3, 63, "R2");
    issue(2, 1, 0, "R4");
    issue(5, 3, 1, "R11");
    issue(7, 2, 1, "R11");
    issue(3, 0, 0, "R5");
    issue(4, 3, 63, "R6");
    issue(1, 3, 4, "R2");
    issue(4, 3, 4, "R7");
    nops(2, "R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule